// File: doc/BRIEF.md
# Slave Reply Manchester Transmitter

This block produces the reply of a field-bus slave once the receiver has taken in a valid request. A one-cycle receive strobe arms it. From that moment all timing is counted in quarter-microsecond units. Shortly after arming, the block lets the line transmitter leave standby. It then opens a short window in which the main control logic may hand over a 4-bit reply word through a valid/ready handshake. At a fixed moment after the strobe, the block sends the word as an active-low Manchester frame. That moment is later when the slave is still in its asynchronous state. During the frame, the block also drives a helper clock whose rising edges fall inside each bit, so that an external shift register can capture the data.

When no reply word arrives in the window, the transmitter goes back to standby and the block stays busy until the bus response time has passed. If another station is heard talking in that time, the block instead waits for the bus pause. After a frame it also waits for the pause, which the shared receiver logic reports, before it accepts a new receive strobe.

The timebase is a prescaler of `Q_CYC` clock cycles per quarter microsecond. Below, one quarter unit is written Q, and a time of nQ equals n × `Q_CYC` clock edges. The reply word is offered with `resp_valid` and is taken on a clock edge where `resp_valid` and `resp_ready` are both high. `resp_ready` is high only during the window. Outside the window, a held `resp_valid` is back-pressured indefinitely and is never taken. A producer that misses the window simply gets no transfer.

Top module: `rsp_tx`

## Requirements
- R1: During and right after reset: `standby`=1, `line_n`=1, `aux_clk`=0, `resp_ready`=0.
- R2: Let edge E0 be the clock edge at which `rx_strobe`=1 is sampled while the block is idle. `standby` goes low at edge E0+2Q.
- R3: `resp_ready` is high from edge E0 until the transfer edge, or until edge E0+24Q if there is no transfer. A transfer takes `resp_data` on an edge with `resp_valid`=1 and `resp_ready`=1. After the window, a held `resp_valid` is not taken.
- R4: `sync_state` is sampled at E0. The frame's first falling edge on `line_n` comes at E0+47Q when `sync_state` was 1, and at E0+49Q when it was 0.
- R5: The frame has 7 bits of 24Q each, sent in this order: start bit 0, then `resp_data` bits [0],[1],[2],[3], then an even parity bit (the XOR of the four data bits), then end bit 1. A 0 is sent as 12Q low then 12Q high; a 1 is sent as 12Q high then 12Q low. Outside a frame, `line_n` is 1.
- R6: `standby` stays low through the whole frame. At the edge that ends the frame, `standby` and `line_n` both return to 1. The block then waits for `pause_seen`.
- R7: If the window closes with no transfer, `standby` returns to 1 at E0+24Q. If `line_active` is seen before E0+240Q, the block waits for `pause_seen`. Otherwise it is idle again at E0+240Q.
- R8: `aux_clk` is 1 from 8Q to 20Q inside each of the 7 bits of a frame. This gives 7 rising edges with a 24Q period, the last one 8Q after the end bit begins. Outside a frame, `aux_clk` is 0.
- R9: `rx_strobe` is ignored whenever the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strobe | input | 1 | One-cycle pulse: a valid request was received |
| sync_state | input | 1 | 1 = slave synchronous, 0 = asynchronous; sampled with the strobe |
| resp_valid | input | 1 | Reply word offered |
| resp_ready | output | 1 | Reply window open |
| resp_data | input | DATA_W | Reply word |
| line_active | input | 1 | Activity heard on the bus |
| pause_seen | input | 1 | Bus pause detected |
| standby | output | 1 | 1 = transmitter in standby |
| line_n | output | 1 | Active-low Manchester output, idle 1 |
| aux_clk | output | 1 | Bit-aligned helper clock |

## Verification
The reply path is swept over every 4-bit word in both synchronous and asynchronous state. The handover cycle is moved across the window, so that an error in the start offset, the bit order, the parity sense or the half-bit polarity shows up as a wrong level at a known quarter. Every edge after the strobe is compared against levels computed arithmetically from the frame definition. Separate patterns cover a missed window and a late hold of valid; strobes that arrive while waiting for a pause; a timed-out response window, which must become idle again; and a response window with bus activity, which must not become idle until the pause.

// File: rtl/rsp_tx_pkg.sv
package rsp_tx_pkg;
  // all timing in quarter-microsecond units
  localparam int Q_STBY        = 2;
  localparam int Q_WIN         = 24;
  localparam int Q_FIRST_SYNC  = 47;
  localparam int Q_FIRST_ASYNC = 49;
  localparam int Q_RESP        = 240;
  localparam int Q_BIT         = 24;
  localparam int Q_HALF        = 12;
  localparam int Q_AUX_RISE    = 8;
  localparam int Q_AUX_FALL    = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LOADED, ST_SEND, ST_NORESP, ST_PAUSE
  } seq_state_t;
endpackage

// File: rtl/rsp_tx_tick.sv
module rsp_tx_tick #(
  parameter int Q_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (Q_CYC > 1) ? $clog2(Q_CYC) : 1;
  localparam logic [PW-1:0] PMAX = PW'(Q_CYC - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pre <= '0;
    else if (restart)      pre <= '0;
    else if (pre == PMAX)  pre <= '0;
    else                   pre <= pre + 1'b1;
  end

  assign tick = (pre == PMAX) && !restart;
endmodule

// File: rtl/rsp_tx_seq.sv
module rsp_tx_seq
  import rsp_tx_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int NB = DATA_W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_strobe,
  input  logic          sync_state,
  input  logic          resp_valid,
  output logic          resp_ready,
  input  logic [DATA_W-1:0] resp_data,
  input  logic          line_active,
  input  logic          pause_seen,
  input  logic          tick,
  input  logic          ser_done,
  output logic          restart,
  output logic          load,
  output logic [NB-1:0] frame,
  output logic          standby
);
  localparam int QW = $clog2(Q_RESP + 1);

  seq_state_t          st;
  logic [QW-1:0]       qcnt;
  logic                mode_sync;
  logic [DATA_W-1:0]   data_q;
  logic [QW-1:0]       first_m1;
  logic                accept;

  assign first_m1 = mode_sync ? QW'(Q_FIRST_SYNC - 1) : QW'(Q_FIRST_ASYNC - 1);
  assign accept   = (st == ST_ARM) && resp_valid;
  assign restart  = (st == ST_IDLE) && rx_strobe;
  assign load     = (st == ST_LOADED) && tick && (qcnt == first_m1);
  assign resp_ready = (st == ST_ARM);
  // start bit 0 at LSB, data LSB first, even parity, end bit 1
  assign frame    = {1'b1, ^data_q, data_q, 1'b0};

  assign standby = !(((st == ST_ARM) || (st == ST_LOADED)) && (qcnt >= QW'(Q_STBY)))
                   && (st != ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      qcnt      <= '0;
      mode_sync <= 1'b0;
      data_q    <= '0;
    end else begin
      if (tick && (qcnt < QW'(Q_RESP))) qcnt <= qcnt + 1'b1;
      case (st)
        ST_IDLE: if (rx_strobe) begin
          st        <= ST_ARM;
          qcnt      <= '0;
          mode_sync <= sync_state;
        end
        ST_ARM: begin
          if (accept) begin
            data_q <= resp_data;
            st     <= ST_LOADED;
          end else if (tick && (qcnt == QW'(Q_WIN - 1))) begin
            st <= ST_NORESP;
          end
        end
        ST_LOADED: if (load) st <= ST_SEND;
        ST_SEND:   if (ser_done) st <= ST_PAUSE;
        ST_NORESP: begin
          if (line_active) st <= ST_PAUSE;
          else if (tick && (qcnt == QW'(Q_RESP - 1))) st <= ST_IDLE;
        end
        ST_PAUSE:  if (pause_seen) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_ready) |-> $past(rx_strobe)); // R3
  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ready && rx_strobe && !resp_valid) |=> resp_ready || !standby || $past(tick)); // R9
endmodule

// File: rtl/rsp_tx_ser.sv
module rsp_tx_ser
  import rsp_tx_pkg::*;
#(
  parameter int NB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NB-1:0] frame,
  input  logic          tick,
  output logic          line_n,
  output logic          aux_clk,
  output logic          done,
  output logic          active
);
  localparam int BW = $clog2(NB);

  logic [NB-1:0] sh;
  logic [BW-1:0] bidx;
  logic [4:0]    qin;

  assign done = active && tick && (qin == 5'(Q_BIT - 1)) && (bidx == BW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      bidx   <= '0;
      qin    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sh     <= frame;
      bidx   <= '0;
      qin    <= '0;
      active <= 1'b1;
    end else if (active && tick) begin
      if (qin == 5'(Q_BIT - 1)) begin
        qin <= '0;
        sh  <= sh >> 1;
        if (bidx == BW'(NB - 1)) active <= 1'b0;
        else                     bidx   <= bidx + 1'b1;
      end else begin
        qin <= qin + 1'b1;
      end
    end
  end

  // 0: low then high, 1: high then low (active-low line)
  assign line_n  = active ? ((qin < 5'(Q_HALF)) ? sh[0] : ~sh[0]) : 1'b1;
  assign aux_clk = active && (qin >= 5'(Q_AUX_RISE)) && (qin < 5'(Q_AUX_FALL));

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active); // R9
  AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(tick) && ($past(qin) == 5'(Q_HALF - 1)))
      |-> (line_n != $past(line_n))); // R5
endmodule

// File: rtl/rsp_tx.sv
module rsp_tx
  import rsp_tx_pkg::*;
#(
  parameter int Q_CYC  = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic              sync_state,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [DATA_W-1:0] resp_data,
  input  logic              line_active,
  input  logic              pause_seen,
  output logic              standby,
  output logic              line_n,
  output logic              aux_clk
);
  localparam int NB = DATA_W + 3;

  logic          tick, restart, load, ser_done, ser_active;
  logic [NB-1:0] frame;

  rsp_tx_tick #(.Q_CYC(Q_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  rsp_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .sync_state(sync_state),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .line_active(line_active), .pause_seen(pause_seen), .tick(tick),
    .ser_done(ser_done), .restart(restart), .load(load), .frame(frame),
    .standby(standby)
  );

  rsp_tx_ser #(.NB(NB)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .frame(frame), .tick(tick),
    .line_n(line_n), .aux_clk(aux_clk), .done(ser_done), .active(ser_active)
  );

  AST_STBY_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ser_active |-> !standby); // R6
  AST_DONE_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    ser_done |=> (standby && line_n)); // R6
  AST_AUX_RISE_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_clk) |-> $stable(line_n)); // R8
endmodule

// File: tb/test_rsp_tx.sv
module test_rsp_tx;
  localparam int QC = 2;
  localparam int NBB = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_strobe = 1'b0, sync_state = 1'b0, resp_valid = 1'b0;
  logic [3:0] resp_data = '0;
  logic line_active = 1'b0, pause_seen = 1'b0;
  logic resp_ready, standby, line_n, aux_clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rsp_tx #(.Q_CYC(QC), .DATA_W(4)) i_rsp_tx (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .sync_state(sync_state),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .line_active(line_active), .pause_seen(pause_seen), .standby(standby),
    .line_n(line_n), .aux_clk(aux_clk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the negedge right after the sampling edge
  task automatic strobe(input logic s);
    rx_strobe = 1'b1; sync_state = s;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_reply(input logic s, input logic [3:0] d, input int k);
    int first, fend, rel, qq, qin, b;
    logic [NBB-1:0] f;
    logic bitv, exp_line, exp_aux, exp_stby;
    first = s ? 47 : 49;
    fend  = (first + NBB * 24) * QC;
    f     = {1'b1, ^d, d, 1'b0};
    strobe(s);
    for (int m = 0; m <= fend + 4; m++) begin
      exp_stby = !((m >= 2 * QC) && (m < fend));
      chk((m < first * QC) ? "R2" : "R6", standby, exp_stby);
      if (m <= k + 3) chk("R3", resp_ready, (m <= k));
      rel = m - first * QC;
      if (rel >= 0 && rel < NBB * 24 * QC) begin
        qq = rel / QC; b = qq / 24; qin = qq % 24;
        bitv = f[b];
        exp_line = (qin < 12) ? bitv : !bitv;
        exp_aux  = (qin >= 8) && (qin < 20);
      end else begin
        exp_line = 1'b1; exp_aux = 1'b0;
      end
      chk((rel >= -2 && rel < 24 * QC) ? "R4" : "R5", line_n, exp_line);
      chk("R8", aux_clk, exp_aux);
      resp_valid = (m == k);
      resp_data  = d;
      @(negedge clk);
    end
    resp_valid = 1'b0;
    // strobe while waiting for the pause must be ignored
    strobe(1'b1);
    for (int i = 0; i < 8; i++) begin
      chk("R9", standby, 1'b1);
      chk("R9", resp_ready, 1'b0);
      @(negedge clk);
    end
    pause_seen = 1'b1; @(negedge clk); pause_seen = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int m;
    idle_cycles(3);
    chk("R1", standby, 1'b1);
    chk("R1", line_n, 1'b1);
    chk("R1", aux_clk, 1'b0);
    chk("R1", resp_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", standby, 1'b1);
    chk("R1", resp_ready, 1'b0);

    // full sweep of words and states with the handover moved across the window
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 16; d++)
        run_reply(s[0], d[3:0], (d * 7 + s * 5) % 48);

    // missed window, valid held afterwards, no bus activity
    strobe(1'b0);
    for (m = 0; m <= 60; m++) begin
      chk("R3", resp_ready, (m <= 47));
      chk("R7", standby, !((m >= 2 * QC) && (m < 48)));
      chk("R7", line_n, 1'b1);
      chk("R7", aux_clk, 1'b0);
      resp_valid = (m >= 48); resp_data = 4'h5;
      @(negedge clk);
    end
    for (; m < 470; m++) @(negedge clk);
    resp_valid = 1'b0;
    strobe(1'b1); m++;
    for (; m < 480; m++) begin
      chk("R9", standby, 1'b1);
      @(negedge clk);
    end
    for (; m < 490; m++) @(negedge clk);
    // response time over: a new strobe is taken
    strobe(1'b0);
    for (m = 0; m < 6; m++) begin
      chk("R7", standby, !(m >= 2 * QC));
      @(negedge clk);
    end
    for (; m < 60; m++) @(negedge clk);
    line_active = 1'b1; @(negedge clk); line_active = 1'b0; m++;
    for (; m < 500; m++) @(negedge clk);
    // with activity seen, still waiting for the pause past the response time
    strobe(1'b1);
    for (int i = 0; i < 8; i++) begin
      chk("R7", standby, 1'b1);
      chk("R7", resp_ready, 1'b0);
      @(negedge clk);
    end
    pause_seen = 1'b1; @(negedge clk); pause_seen = 1'b0;
    @(negedge clk);
    run_reply(1'b1, 4'hA, 3);
    run_reply(1'b0, 4'h7, 47);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule